// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading a four-level radix page table from memory. A requester presents a virtual address together with an access kind (read, write or execute) and a user/supervisor flag. The walker samples the root table location from a base input at that moment. It then issues one 64-bit entry read per level on a simple request/response memory port, and finishes with either a physical address or a fault code naming the level that caused it. The 12-bit page offset never passes through the table: it is copied straight into the result.

The walker handles one request at a time. Its controller has five named states. **IDLE** accepts a request (transition *accept*, to ISSUE). **ISSUE** drives a single memory read for the current level (transition *send*, to WAIT). **WAIT** holds until the response arrives, and then takes one of three transitions: *descend* back to ISSUE when the entry is present and levels remain, *absent* to DONE when the present bit is clear, or *last* to CHECK after a present final-level entry. **CHECK** evaluates the accumulated permissions (transition *judge*, to DONE). **DONE** presents the result for exactly one cycle (transition *release*, to IDLE).

Entry layout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 63 no-execute, bits 47:12 the frame number of the next table or of the page. Every other entry bit is ignored. Access codes: 0 read, 1 write, 2 execute, 3 treated as read. Fault causes: 0 none, 1 not present, 2 protection, 3 privilege.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted, req_ready is 1, done is 0 and mem_req_valid is 0.
- R2: A request is taken in a cycle where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 until done has pulsed. done is high for exactly one cycle, and req_ready is 1 again in the cycle after that.
- R3: The read for level 0 goes to address {root_base[47:12], va[47:39], 3'b000}, where root_base is sampled when the request is taken. Levels 1, 2 and 3 use the index slices va[38:30], va[29:21] and va[20:12].
- R4: The table frame used at level L+1 is bits 47:12 of the entry returned for level L.
- R5: At most one memory read is outstanding. mem_req_valid is high for one cycle per level, and the next read starts only after the previous response has arrived, whatever the response latency.
- R6: If an entry has bit 0 clear, the walk stops at once with done_fault=1, done_cause=1 and done_level equal to that level (0 to 3). No further reads are issued. This fault takes precedence over any permission fault.
- R7: On success done_fault=0, done_cause=0, done_level=3 and done_pa={final entry[47:12], va[11:0]}.
- R8: If the user flag is 1 and any of the four entries has bit 2 clear, the result is a fault with cause 3 at level 3. This check has the highest priority among the permission checks.
- R9: If the access code is 1 (write) and any entry has bit 1 clear, and R8 does not apply, the result is a fault with cause 2 at level 3.
- R10: If the access code is 2 (execute) and any entry has bit 63 set, and R8 does not apply, the result is a fault with cause 2. Access codes 0 and 3 ignore bits 1 and 63.
- R11: On any fault done_pa is zero.
- R12: The same virtual address translated under two different root_base values walks different tables and yields the physical address of each table's chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 48 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_user | input | 1 | 1 for a user-mode access |
| root_base | input | 48 | Physical address of the root table (bits 47:12 used) |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | 48 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Returned page table entry |
| done | output | 1 | One-cycle completion pulse |
| done_pa | output | 48 | Physical address, zero on fault |
| done_fault | output | 1 | Translation faulted |
| done_cause | output | 2 | 0 none, 1 not present, 2 protection, 3 privilege |
| done_level | output | 2 | Level that faulted (3 for permission faults and success) |

## Verification
On every cycle the assertions enforce the handshake: ready drops after acceptance, done lasts one cycle, and no second read is issued while one is outstanding. They also check that an absent entry leads straight to a not-present completion, that a fault never carries a physical address, that permission faults report the last level, and that a successful result keeps the virtual offset. Only the bench scenarios can show that the entry addresses follow the index slices and chain from one level's frame to the next. The same holds for the priority among privilege, write and execute faults under every mix of entry bits at each level, the behaviour under a change of root, and the fact that ignored entry bits do not reach the result.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    // access kinds presented with a request
    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    // entry flag positions
    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;
    localparam int FLAG_NOEXEC  = 63;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PROT   = 2'd2,
        CAUSE_PRIV   = 2'd3
    } walk_cause_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_CHECK,
        ST_DONE
    } walk_state_t;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 48,
    parameter int ESZ_LG = 3
) (
    input  logic [PA_W-OFF_W-1:0]     table_frame,
    input  logic [LEVELS*IDX_W-1:0]   vpn,
    input  logic [$clog2(LEVELS)-1:0] level,
    output logic [PA_W-1:0]           entry_addr
);

    logic [IDX_W-1:0] slice [LEVELS];

    // level 0 takes the most significant slice of the page number
    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_slice
            assign slice[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
        end
    endgenerate

    always_comb begin
        entry_addr = {table_frame, {OFF_W{1'b0}}}
                   | (PA_W'(slice[level]) << ESZ_LG);
    end

endmodule

// File: rtl/pt_perm_acc.sv
module pt_perm_acc
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        capture,
    input  logic        ent_write,
    input  logic        ent_user,
    input  logic        ent_noexec,
    input  logic [1:0]  acc,
    input  logic        user,
    output logic        perm_fault,
    output walk_cause_t perm_cause
);

    logic all_write, all_user, any_noexec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            all_write  <= 1'b1;
            all_user   <= 1'b1;
            any_noexec <= 1'b0;
        end else if (clear) begin
            all_write  <= 1'b1;
            all_user   <= 1'b1;
            any_noexec <= 1'b0;
        end else if (capture) begin
            all_write  <= all_write & ent_write;
            all_user   <= all_user & ent_user;
            any_noexec <= any_noexec | ent_noexec;
        end
    end

    always_comb begin
        if (user && !all_user)
            perm_cause = CAUSE_PRIV;
        else if (acc == ACC_WRITE && !all_write)
            perm_cause = CAUSE_PROT;
        else if (acc == ACC_EXEC && any_noexec)
            perm_cause = CAUSE_PROT;
        else
            perm_cause = CAUSE_NONE;
        perm_fault = (perm_cause != CAUSE_NONE);
    end

    // R10: a no-execute mark seen during a walk is never forgotten before the next clear
    assert_noexec_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_noexec && !clear) |=> any_noexec);

    // R9: a new walk starts with all permissions granted
    assert_clear_grants_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (all_write && all_user && !any_noexec));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int VA_W    = 48,
    parameter int PA_W    = 48,
    parameter int ENTRY_W = 64,
    parameter int LEVELS  = 4,
    parameter int IDX_W   = 9,
    parameter int OFF_W   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_va,
    input  logic [1:0]                req_acc,
    input  logic                      req_user,
    input  logic [PA_W-1:0]           root_base,
    output logic                      mem_req_valid,
    output logic [PA_W-1:0]           mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [ENTRY_W-1:0]        mem_rsp_data,
    output logic                      done,
    output logic [PA_W-1:0]           done_pa,
    output logic                      done_fault,
    output logic [1:0]                done_cause,
    output logic [$clog2(LEVELS)-1:0] done_level
);

    localparam int LVL_W   = $clog2(LEVELS);
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int VPN_W   = LEVELS * IDX_W;
    localparam int ESZ_LG  = $clog2(ENTRY_W / 8);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

    walk_state_t        state, state_nx;
    logic [VA_W-1:0]    va_q;
    logic [1:0]         acc_q;
    logic               user_q;
    logic [FRAME_W-1:0] frame_q;
    logic [LVL_W-1:0]   level_q;
    logic [PA_W-1:0]    pa_q;
    logic               fault_q;
    walk_cause_t        cause_q;
    logic [LVL_W-1:0]   flevel_q;
    logic               outstanding;

    logic               accept, rsp_take, present, at_last;
    logic               perm_fault;
    walk_cause_t        perm_cause;
    logic [PA_W-1:0]    entry_addr;
    logic               unused_bits;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign rsp_take = (state == ST_WAIT) && mem_rsp_valid;
    assign present  = mem_rsp_data[FLAG_PRESENT];
    assign at_last  = (level_q == LAST);

    assign unused_bits = ^{mem_rsp_data[ENTRY_W-2:PA_W], mem_rsp_data[OFF_W-1:FLAG_USER+1],
                           root_base[OFF_W-1:0]};

    pt_entry_addr #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .PA_W   (PA_W),
        .ESZ_LG (ESZ_LG)
    ) i_entry_addr (
        .table_frame (frame_q),
        .vpn         (va_q[OFF_W +: VPN_W]),
        .level       (level_q),
        .entry_addr  (entry_addr)
    );

    pt_perm_acc i_perm_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .capture    (rsp_take && present),
        .ent_write  (mem_rsp_data[FLAG_WRITE]),
        .ent_user   (mem_rsp_data[FLAG_USER]),
        .ent_noexec (mem_rsp_data[FLAG_NOEXEC]),
        .acc        (acc_q),
        .user       (user_q),
        .perm_fault (perm_fault),
        .perm_cause (perm_cause)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;          // accept
            ST_ISSUE: state_nx = ST_WAIT;                          // send
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!present)     state_nx = ST_DONE;          // absent
                    else if (at_last) state_nx = ST_CHECK;         // last
                    else              state_nx = ST_ISSUE;         // descend
                end
            end
            ST_CHECK: state_nx = ST_DONE;                          // judge
            ST_DONE:  state_nx = ST_IDLE;                          // release
            default:  state_nx = ST_IDLE;
        endcase
    end

    // walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            acc_q    <= ACC_READ;
            user_q   <= 1'b0;
            frame_q  <= '0;
            level_q  <= '0;
            pa_q     <= '0;
            fault_q  <= 1'b0;
            cause_q  <= CAUSE_NONE;
            flevel_q <= '0;
        end else begin
            if (accept) begin
                va_q    <= req_va;
                acc_q   <= req_acc;
                user_q  <= req_user;
                frame_q <= root_base[PA_W-1:OFF_W];
                level_q <= '0;
            end
            if (rsp_take) begin
                if (present) begin
                    frame_q <= mem_rsp_data[PA_W-1:OFF_W];
                    if (!at_last) level_q <= level_q + 1'b1;
                end else begin
                    fault_q  <= 1'b1;
                    cause_q  <= CAUSE_ABSENT;
                    flevel_q <= level_q;
                    pa_q     <= '0;
                end
            end
            if (state == ST_CHECK) begin
                flevel_q <= LAST;
                fault_q  <= perm_fault;
                cause_q  <= perm_cause;
                pa_q     <= perm_fault ? '0 : {frame_q, va_q[OFF_W-1:0]};
            end
        end
    end

    // read tracker used by the one-outstanding check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             outstanding <= 1'b0;
        else if (mem_req_valid) outstanding <= 1'b1;
        else if (mem_rsp_valid) outstanding <= 1'b0;
    end

    // outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = entry_addr;
        done          = (state == ST_DONE);
        done_pa       = pa_q;
        done_fault    = fault_q;
        done_cause    = cause_q;
        done_level    = flevel_q;
    end

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !outstanding);

    assert_absent_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && !present) |=> (done && done_fault && done_cause == CAUSE_ABSENT));

    assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (done_pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

    assert_perm_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (done_cause == CAUSE_PRIV || done_cause == CAUSE_PROT)) |-> (done_level == LAST));

    assert_fault_pa_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_pa == '0));

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [47:0] root_base = '0;
    logic        mem_req_valid;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [47:0] done_pa;
    logic        done_fault;
    logic [1:0]  done_cause;
    logic [1:0]  done_level;

    int checks = 0;
    int fails  = 0;

    // per-level entry flags used by the memory model
    logic [3:0] g_wr = 4'hF;
    logic [3:0] g_us = 4'hF;
    logic [3:0] g_nx = 4'h0;
    logic [3:0] g_np = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .req_acc       (req_acc),
        .req_user      (req_user),
        .root_base     (root_base),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .done_pa       (done_pa),
        .done_fault    (done_fault),
        .done_cause    (done_cause),
        .done_level    (done_level)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] next_frame(input logic [47:0] a);
        return 36'((a[47:12] * 36'd3) + {27'd0, a[11:3]} + 36'h5);
    endfunction

    function automatic logic [63:0] make_entry(input logic [47:0] a, input int lvl);
        logic [63:0] e;
        e = '0;
        e[47:12] = next_frame(a);
        e[62:48] = 15'h5a3c;   // ignored bits
        e[11:3]  = 9'h1a5;     // ignored bits
        e[0]  = !g_np[lvl];
        e[1]  = g_wr[lvl];
        e[2]  = g_us[lvl];
        e[63] = g_nx[lvl];
        return e;
    endfunction

    task automatic run_walk(input logic [47:0] va, input logic [47:0] base,
                            input logic [1:0] acc, input bit user,
                            output logic [47:0] got_pa);
        logic [47:0] exp_addr [4];
        logic [35:0] frame;
        logic [47:0] a;
        int          exp_reads;
        bit          exp_fault;
        logic [1:0]  exp_cause, exp_level;
        logic [47:0] exp_pa;
        string       tag;
        int          r;
        int          guard;

        frame     = base[47:12];
        exp_reads = 4;
        exp_fault = 1'b0;
        exp_cause = 2'd0;
        exp_level = 2'd3;
        for (int l = 0; l < 4; l++) begin
            exp_addr[l] = {frame, 12'h000} | (48'(va[47-9*l -: 9]) << 3);
            if (!exp_fault) begin
                if (g_np[l]) begin
                    exp_fault = 1'b1; exp_cause = 2'd1;
                    exp_level = 2'(l); exp_reads = l + 1;
                end else begin
                    frame = next_frame(exp_addr[l]);
                end
            end
        end
        if (!exp_fault) begin
            if (user && !(&g_us))              begin exp_fault = 1; exp_cause = 2'd3; end
            else if (acc == 2'd1 && !(&g_wr))  begin exp_fault = 1; exp_cause = 2'd2; end
            else if (acc == 2'd2 && (|g_nx))   begin exp_fault = 1; exp_cause = 2'd2; end
        end
        exp_pa = exp_fault ? 48'd0 : {frame, va[11:0]};
        case (exp_cause)
            2'd1:    tag = "R6";
            2'd3:    tag = "R8";
            2'd2:    tag = (acc == 2'd1) ? "R9" : "R10";
            default: tag = "R7";
        endcase

        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user; root_base = base;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        root_base = ~base;  // later changes must not affect this walk
        chk(req_ready == 1'b0, "R2", "ready low while walking", 64'(req_ready), 64'd0);

        r = 0;
        guard = 0;
        while (done !== 1'b1 && guard < 100) begin
            if (mem_req_valid === 1'b1) begin
                a = mem_req_addr;
                chk(r < exp_reads, "R6", "read count", 64'(r + 1), 64'(exp_reads));
                chk(a == exp_addr[r & 3], (r == 0) ? "R3" : "R4", "entry address",
                    64'(a), 64'(exp_addr[r & 3]));
                @(posedge clk);
                @(negedge clk);
                chk(mem_req_valid == 1'b0, "R5", "single request pulse", 64'(mem_req_valid), 64'd0);
                repeat (r) begin
                    @(posedge clk);
                    @(negedge clk);
                    chk(mem_req_valid == 1'b0, "R5", "no read while waiting", 64'(mem_req_valid), 64'd0);
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = make_entry(a, r & 3);
                @(posedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                r++;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
        chk(done === 1'b1, "R2", "done reached", 64'(done), 64'd1);
        chk(r == exp_reads, (exp_cause == 2'd1) ? "R6" : "R5", "reads issued", 64'(r), 64'(exp_reads));
        chk(done_fault == exp_fault, tag, "fault flag", 64'(done_fault), 64'(exp_fault));
        chk(done_cause == exp_cause, tag, "fault cause", 64'(done_cause), 64'(exp_cause));
        chk(done_level == exp_level, tag, "fault level", 64'(done_level), 64'(exp_level));
        chk(done_pa == exp_pa, exp_fault ? "R11" : "R7", "physical address", 64'(done_pa), 64'(exp_pa));
        got_pa = done_pa;
        @(negedge clk);
        chk(done == 1'b0, "R2", "done one cycle", 64'(done), 64'd0);
        chk(req_ready == 1'b1, "R2", "ready after done", 64'(req_ready), 64'd1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        logic [47:0] pa_a, pa_b, pa_tmp;
        logic [47:0] va;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "reset mem request", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // permission sweep: every level gets a denied bit of each kind in turn
        for (int pat = 0; pat < 16; pat++) begin
            for (int acc = 0; acc < 4; acc++) begin
                for (int user = 0; user < 2; user++) begin
                    logic [3:0] p;
                    p    = 4'(pat);
                    g_wr = ~(4'(p[0]) << p[3:2]);
                    g_us = ~(4'(p[1]) << p[3:2]);
                    g_nx = 4'(p[2]) << p[1:0];
                    g_np = 4'h0;
                    va = 48'h8123_4567_89ab ^ (48'(pat * 37 + acc * 5 + user) * 48'h0001_0040_2009);
                    run_walk(va, 48'h0000_0012_3000 + 48'(pat << 12), 2'(acc), user[0], pa_tmp);
                end
            end
        end

        // R6: not-present at each level, also with permissions denied everywhere
        for (int lvl = 0; lvl < 4; lvl++) begin
            g_wr = 4'hF; g_us = 4'hF; g_nx = 4'h0;
            g_np = 4'b1 << lvl;
            run_walk(48'h7f3c_1234_5678 + 48'(lvl * 48'h0000_4020_1000), 48'h0000_0040_0000, 2'd0, 1'b0, pa_tmp);
            g_wr = 4'h0; g_us = 4'h0; g_nx = 4'hF;
            g_np = (4'b1 << lvl) | 4'b1000;
            run_walk(48'h0123_4567_8000, 48'h0000_0050_0000, 2'd1, 1'b1, pa_tmp);
        end

        // R7: offset sweep across the 12-bit field
        g_wr = 4'hF; g_us = 4'hF; g_nx = 4'h0; g_np = 4'h0;
        for (int k = 0; k < 12; k++) begin
            run_walk({36'h9_8765_4321, 12'(1 << k)}, 48'h0000_0001_0000, 2'd0, 1'b0, pa_tmp);
        end
        run_walk({36'h9_8765_4321, 12'hfff}, 48'h0000_0001_0000, 2'd2, 1'b1, pa_tmp);
        run_walk({36'h0_0000_0000, 12'h000}, 48'h0000_0001_0000, 2'd1, 1'b1, pa_tmp);

        // R10: read-like codes ignore writable and no-execute bits
        g_wr = 4'h0; g_nx = 4'hF;
        run_walk(48'h4444_3333_2abc, 48'h0000_0002_0000, 2'd3, 1'b0, pa_tmp);
        chk(pa_tmp[11:0] == 12'habc, "R10", "code 3 is a read", 64'(pa_tmp[11:0]), 64'habc);

        // R12: same virtual address under two roots
        g_wr = 4'hF; g_nx = 4'h0;
        run_walk(48'h5555_aaaa_1234, 48'h0000_0003_0000, 2'd0, 1'b0, pa_a);
        run_walk(48'h5555_aaaa_1234, 48'h0000_0077_7000, 2'd0, 1'b0, pa_b);
        chk(pa_a != pa_b, "R12", "roots give different results", 64'(pa_b), 64'(~pa_a));

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule